// File: doc/BRIEF.md
# Banked General Register File

This block holds the general-purpose registers of a 32-bit processor core. Sixteen architectural registers are visible to ordinary instructions. The lowest eight of them have two physical copies, called bank 0 and bank 1, and the upper eight exist only once. A bank-select input, driven by a status bit that lives outside the block, picks which copy of the low eight appears to ordinary instructions. The copy that is not selected stays reachable through a separate alternate-bank port. Privileged control-register moves use that port to save or restore the other bank's contents, for example while an exception handler runs.

Ordinary instructions use two combinational read ports and one write port. The alternate-bank port has its own three-bit index and its own read and write data. A dedicated output always carries the R0 of the selected bank, because the address generator uses that register as an index without spending a read port. All 24 physical words clear to zero on a synchronous reset. Register contents survive any number of bank switches.

Top module: `bankreg_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 24 physical registers to zero, and reset overrides any write in the same cycle.
- R2: A read-port address of 0 to 7 returns the bank-1 copy when `bank_sel` is 1 and the bank-0 copy when `bank_sel` is 0.
- R3: Addresses 8 to 15 name one shared copy that returns the same value whichever way `bank_sel` is set.
- R4: The alternate port reads and writes entry `alt_addr` (0 to 7) of the bank that `bank_sel` does not select (bank 0 when `bank_sel`=1, bank 1 when `bank_sel`=0).
- R5: A write through the alternate port changes neither the selected bank nor addresses 8 to 15.
- R6: Both read ports are combinational. A write becomes visible after the rising edge that stores it, and a read in the same cycle as the write returns the old value.
- R7: `idx_data` always equals register 0 of the selected bank.
- R8: A change of `bank_sel` changes what the read ports return in that same cycle and keeps the contents of both banks.
- R9: While `wr_en` is 0, `wr_addr` and `wr_data` change no register.
- R10: A normal write to addresses 0 to 7 lands in the bank that `bank_sel` selects in the cycle of the write, including a cycle in which `bank_sel` has just changed. If both write ports name the same physical register, the normal port wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | 1 | Selected bank for addresses 0 to 7 |
| rd_a_addr | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_addr | input | 4 | Normal write register number |
| wr_data | input | 32 | Normal write data |
| alt_addr | input | 3 | Entry in the bank that is not selected |
| alt_wr_en | input | 1 | Alternate-bank write enable |
| alt_wr_data | input | 32 | Alternate-bank write data |
| alt_rd_data | output | 32 | Alternate-bank read data |
| idx_data | output | 32 | Register 0 of the selected bank |

## Verification
The read data, the alternate read data and the index output are due in the same cycle as their addresses and bank select, so the bench samples them 2 ns after it drives them at a falling edge, well before the next rising edge. A write is due one rising edge later. The bench checks the old value in the write's own cycle and updates its reference array only after that edge, so that every later probe expects the new value. Bank-select changes are probed in the cycle of the change, with no extra wait.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

   typedef enum logic {
      BANK_ZERO = 1'b0,
      BANK_ONE  = 1'b1
   } bank_id_e;

   // Index width for a table of n entries, never below one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/bankreg_bank_array.sv
// Two physical copies of the low registers, with per-cell write steering.
module bankreg_bank_array #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_BANKED = 8,
   localparam int unsigned BAW       = bankreg_pkg::idx_width(NUM_BANKED)
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 bank_sel,
   input  logic                                 nrm_we,
   input  logic [BAW-1:0]                       nrm_idx,
   input  logic [DATA_W-1:0]                    nrm_data,
   input  logic                                 alt_we,
   input  logic [BAW-1:0]                       alt_idx,
   input  logic [DATA_W-1:0]                    alt_data,
   output logic [NUM_BANKED-1:0][DATA_W-1:0]    act_q,
   output logic [NUM_BANKED-1:0][DATA_W-1:0]    oth_q
);
   import bankreg_pkg::*;

   localparam int unsigned NUM_BANKS = 2;

   logic [DATA_W-1:0] cell_view [NUM_BANKS][NUM_BANKED];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar e = 0; e < NUM_BANKED; e++) begin : g_cell
         logic              hit_nrm;
         logic              hit_alt;
         logic [DATA_W-1:0] cell_q;

         assign hit_nrm = nrm_we && (bank_sel == 1'(b))
                                 && (nrm_idx == BAW'(e));
         assign hit_alt = alt_we && (bank_sel != 1'(b))
                                 && (alt_idx == BAW'(e));

         // Reset first, then the normal port, then the alternate port.
         always_ff @(posedge clk) begin
            if (rst)
               cell_q <= '0;
            else if (hit_nrm)
               cell_q <= nrm_data;
            else if (hit_alt)
               cell_q <= alt_data;
         end

         assign cell_view[b][e] = cell_q;
      end
   end

   for (genvar e = 0; e < NUM_BANKED; e++) begin : g_steer
      always_comb begin
         if (bank_id_e'(bank_sel) == BANK_ONE) begin
            act_q[e] = cell_view[1][e];
            oth_q[e] = cell_view[0][e];
         end else begin
            act_q[e] = cell_view[0][e];
            oth_q[e] = cell_view[1][e];
         end
      end
   end

endmodule

// File: rtl/bankreg_shared_array.sv
// Single-copy upper registers, written only by the normal port.
module bankreg_shared_array #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_SHARED = 8,
   localparam int unsigned SBW       = bankreg_pkg::idx_width(NUM_SHARED)
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 we,
   input  logic [SBW-1:0]                       idx,
   input  logic [DATA_W-1:0]                    data,
   output logic [NUM_SHARED-1:0][DATA_W-1:0]    q
);

   for (genvar e = 0; e < NUM_SHARED; e++) begin : g_cell
      logic              hit;
      logic [DATA_W-1:0] cell_q;

      assign hit = we && (idx == SBW'(e));

      always_ff @(posedge clk) begin
         if (rst)
            cell_q <= '0;
         else if (hit)
            cell_q <= data;
      end

      assign q[e] = cell_q;
   end

endmodule

// File: rtl/bankreg_read_mux.sv
// Combinational read selector; the variant is chosen by a parameter.
module bankreg_read_mux #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_ENT = 16,
   parameter bit          AND_OR  = 1'b0,
   localparam int unsigned IW     = bankreg_pkg::idx_width(NUM_ENT)
) (
   input  logic [NUM_ENT-1:0][DATA_W-1:0] ent,
   input  logic [IW-1:0]                  sel,
   output logic [DATA_W-1:0]              data
);

   if (AND_OR) begin : g_and_or
      // Flat decode followed by an OR of masked words.
      always_comb begin
         data = '0;
         for (int i = 0; i < NUM_ENT; i++) begin
            data = data | (ent[i] & {DATA_W{sel == IW'(i)}});
         end
      end
   end else begin : g_index
      always_comb begin
         data = ent[sel];
      end
   end

endmodule

// File: rtl/bankreg_file.sv
// Top level: banked low registers, shared high registers, three read paths.
module bankreg_file #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_REGS    = 16,
   parameter int unsigned NUM_BANKED  = 8,
   parameter bit          AND_OR_READ = 1'b0,
   localparam int unsigned AW  = bankreg_pkg::idx_width(NUM_REGS),
   localparam int unsigned BAW = bankreg_pkg::idx_width(NUM_BANKED)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bank_sel,
   input  logic [AW-1:0]     rd_a_addr,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [AW-1:0]     rd_b_addr,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BAW-1:0]    alt_addr,
   input  logic              alt_wr_en,
   input  logic [DATA_W-1:0] alt_wr_data,
   output logic [DATA_W-1:0] alt_rd_data,
   output logic [DATA_W-1:0] idx_data
);
   import bankreg_pkg::*;

   localparam int unsigned NUM_SHARED = NUM_REGS - NUM_BANKED;
   localparam int unsigned SBW        = idx_width(NUM_SHARED);
   localparam logic [AW-1:0] LOW_LIM  = AW'(NUM_BANKED);

   // Elaboration-time parameter checks.
   if (DATA_W < 1) begin : g_bad_width
      $error("bankreg_file: DATA_W must be at least 1");
   end
   if (!is_pow2(NUM_REGS) || NUM_REGS < 4) begin : g_bad_regs
      $error("bankreg_file: NUM_REGS must be a power of two, at least 4");
   end
   if (!is_pow2(NUM_BANKED) || NUM_BANKED >= NUM_REGS) begin : g_bad_bank
      $error("bankreg_file: NUM_BANKED must be a power of two below NUM_REGS");
   end

   // Normal write decode: low addresses go to the banks, the rest are shared.
   logic              wr_low;
   logic [BAW-1:0]    wr_low_idx;
   logic [SBW-1:0]    wr_shr_idx;
   logic [AW-1:0]     wr_shr_off;

   assign wr_low     = wr_addr < LOW_LIM;
   assign wr_low_idx = wr_addr[BAW-1:0];
   assign wr_shr_off = wr_addr - LOW_LIM;
   assign wr_shr_idx = wr_shr_off[SBW-1:0];

   logic [NUM_BANKED-1:0][DATA_W-1:0] act_q;
   logic [NUM_BANKED-1:0][DATA_W-1:0] oth_q;
   logic [NUM_SHARED-1:0][DATA_W-1:0] shr_q;
   logic [NUM_REGS-1:0][DATA_W-1:0]   view;

   bankreg_bank_array #(
      .DATA_W     (DATA_W),
      .NUM_BANKED (NUM_BANKED)
   ) u_banks (
      .clk      (clk),
      .rst      (rst),
      .bank_sel (bank_sel),
      .nrm_we   (wr_en && wr_low),
      .nrm_idx  (wr_low_idx),
      .nrm_data (wr_data),
      .alt_we   (alt_wr_en),
      .alt_idx  (alt_addr),
      .alt_data (alt_wr_data),
      .act_q    (act_q),
      .oth_q    (oth_q)
   );

   bankreg_shared_array #(
      .DATA_W     (DATA_W),
      .NUM_SHARED (NUM_SHARED)
   ) u_shared (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_en && !wr_low),
      .idx  (wr_shr_idx),
      .data (wr_data),
      .q    (shr_q)
   );

   // Architectural view seen by ordinary instructions.
   assign view[NUM_BANKED-1:0]        = act_q;
   assign view[NUM_REGS-1:NUM_BANKED] = shr_q;

   bankreg_read_mux #(
      .DATA_W  (DATA_W),
      .NUM_ENT (NUM_REGS),
      .AND_OR  (AND_OR_READ)
   ) u_rd_a (
      .ent  (view),
      .sel  (rd_a_addr),
      .data (rd_a_data)
   );

   bankreg_read_mux #(
      .DATA_W  (DATA_W),
      .NUM_ENT (NUM_REGS),
      .AND_OR  (AND_OR_READ)
   ) u_rd_b (
      .ent  (view),
      .sel  (rd_b_addr),
      .data (rd_b_data)
   );

   bankreg_read_mux #(
      .DATA_W  (DATA_W),
      .NUM_ENT (NUM_BANKED),
      .AND_OR  (AND_OR_READ)
   ) u_rd_alt (
      .ent  (oth_q),
      .sel  (alt_addr),
      .data (alt_rd_data)
   );

   // Index register tap: entry 0 of the selected bank, no port needed.
   assign idx_data = act_q[0];

endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_REGS   = 16,
   parameter int unsigned NUM_BANKED = 8,
   localparam int unsigned AW  = bankreg_pkg::idx_width(NUM_REGS),
   localparam int unsigned BAW = bankreg_pkg::idx_width(NUM_BANKED)
) (
   input logic              clk,
   input logic              rst,
   input logic              bank_sel,
   input logic [AW-1:0]     rd_a_addr,
   input logic [DATA_W-1:0] rd_a_data,
   input logic              wr_en,
   input logic [AW-1:0]     wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [BAW-1:0]    alt_addr,
   input logic              alt_wr_en,
   input logic [DATA_W-1:0] alt_wr_data,
   input logic [DATA_W-1:0] alt_rd_data,
   input logic [DATA_W-1:0] idx_data
);
   localparam logic [AW-1:0] LOW_LIM = AW'(NUM_BANKED);

   // R1: after a reset edge the selected and the other bank read zero.
   p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> (idx_data == '0) && (alt_rd_data == '0));

   // R7: port A at address 0 agrees with the dedicated index tap.
   p_index_tap_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_a_addr == '0) |-> (rd_a_data == idx_data));

   // R6: a normal write is visible one edge later at the same address and bank.
   p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (!((rd_a_addr == $past(wr_addr)) && (bank_sel == $past(bank_sel)))
                 || (rd_a_data == $past(wr_data))));

   // R4: an alternate write is visible on the alternate read one edge later.
   p_alt_lands_r4: assert property (@(posedge clk) disable iff (rst)
      alt_wr_en |=> (!((alt_addr == $past(alt_addr)) && (bank_sel == $past(bank_sel)))
                     || (alt_rd_data == $past(alt_wr_data))));

   // R3: shared registers do not move when only the bank select changes.
   p_shared_fixed_r3: assert property (@(posedge clk) disable iff (rst)
      ((bank_sel != $past(bank_sel)) && !$past(wr_en) && !$past(rst)
       && (rd_a_addr == $past(rd_a_addr)) && (rd_a_addr >= LOW_LIM))
      |-> (rd_a_data == $past(rd_a_data)));

   // R5: with no alternate write and a steady select, the other bank holds.
   p_other_bank_holds_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(alt_wr_en) && !$past(rst) && (bank_sel == $past(bank_sel))
       && (alt_addr == $past(alt_addr)))
      |-> (alt_rd_data == $past(alt_rd_data)));

endmodule

bind bankreg_file bankreg_file_chk #(
   .DATA_W     (DATA_W),
   .NUM_REGS   (NUM_REGS),
   .NUM_BANKED (NUM_BANKED)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .bank_sel    (bank_sel),
   .rd_a_addr   (rd_a_addr),
   .rd_a_data   (rd_a_data),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .alt_addr    (alt_addr),
   .alt_wr_en   (alt_wr_en),
   .alt_wr_data (alt_wr_data),
   .alt_rd_data (alt_rd_data),
   .idx_data    (idx_data)
);

// File: tb/bankreg_file_tb_top.sv
module bankreg_file_tb_top;

   typedef struct {
      string       tag;
      int          port;
      logic [31:0] exp;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bank_sel = 1'b0;
   logic [3:0]  rd_a_addr = '0;
   logic [3:0]  rd_b_addr = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  alt_addr = '0;
   logic        alt_wr_en = 1'b0;
   logic [31:0] alt_wr_data = '0;
   logic [31:0] rd_a_data, rd_b_data, alt_rd_data, idx_data;

   always #10 clk = ~clk;   // 50 MHz

   bankreg_file dut_i (
      .clk         (clk),
      .rst         (rst),
      .bank_sel    (bank_sel),
      .rd_a_addr   (rd_a_addr),
      .rd_a_data   (rd_a_data),
      .rd_b_addr   (rd_b_addr),
      .rd_b_data   (rd_b_data),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .alt_addr    (alt_addr),
      .alt_wr_en   (alt_wr_en),
      .alt_wr_data (alt_wr_data),
      .alt_rd_data (alt_rd_data),
      .idx_data    (idx_data)
   );

   // Reference model.
   logic [31:0] m_b0 [8];
   logic [31:0] m_b1 [8];
   logic [31:0] m_hi [8];

   int    n_run  = 0;
   int    n_fail = 0;
   item_t sb_q[$];
   event  go;

   function automatic logic [31:0] exp_norm(input logic bsel, input logic [3:0] a);
      if (a < 4'd8) return bsel ? m_b1[a[2:0]] : m_b0[a[2:0]];
      return m_hi[a[2:0]];
   endfunction

   function automatic logic [31:0] exp_alt(input logic bsel, input logic [2:0] a);
      return bsel ? m_b0[a] : m_b1[a];
   endfunction

   task automatic push(input string tag, input int port, input logic [31:0] exp);
      item_t it;
      it.tag = tag; it.port = port; it.exp = exp;
      sb_q.push_back(it);
   endtask

   task automatic settle();
      ->go;
      #3;
   endtask

   // Monitor: pops expected items and compares them with the outputs.
   initial begin
      forever begin
         @(go);
         #1;
         while (sb_q.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.port)
               0:       act = rd_a_data;
               1:       act = rd_b_data;
               2:       act = alt_rd_data;
               default: act = idx_data;
            endcase
            n_run++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s port %0d actual %h expected %h", it.tag, it.port, act, it.exp);
            end
         end
      end
   end

   task automatic clear_model();
      for (int i = 0; i < 8; i++) begin
         m_b0[i] = '0; m_b1[i] = '0; m_hi[i] = '0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      clear_model();
      #1 rst = 1'b0;
   endtask

   // Probe all combinational outputs in one cycle.
   task automatic probe(input string t_rd, input logic bsel, input logic [3:0] ra,
                        input logic [3:0] rb, input logic [2:0] aa);
      @(negedge clk);
      bank_sel = bsel; rd_a_addr = ra; rd_b_addr = rb; alt_addr = aa;
      wr_en = 1'b0; alt_wr_en = 1'b0;
      #2;
      push(t_rd, 0, exp_norm(bsel, ra));
      push(t_rd, 1, exp_norm(bsel, rb));
      push("R4", 2, exp_alt(bsel, aa));
      push("R7", 3, exp_norm(bsel, 4'd0));
      settle();
   endtask

   // One write cycle; port A watches the written address for the old value (R6).
   task automatic do_write(input logic bsel, input logic we, input logic [3:0] wa,
                           input logic [31:0] wd, input logic awe,
                           input logic [2:0] aa, input logic [31:0] ad);
      @(negedge clk);
      bank_sel = bsel; wr_en = we; wr_addr = wa; wr_data = wd;
      alt_wr_en = awe; alt_addr = aa; alt_wr_data = ad; rd_a_addr = wa;
      #2;
      push("R6", 0, exp_norm(bsel, wa));
      settle();
      @(posedge clk);
      // Alternate write first so the normal port wins a shared target (R10).
      if (awe) begin
         if (bsel) m_b0[aa] = ad; else m_b1[aa] = ad;
      end
      if (we) begin
         if (wa < 4'd8) begin
            if (bsel) m_b1[wa[2:0]] = wd; else m_b0[wa[2:0]] = wd;
         end else begin
            m_hi[wa[2:0]] = wd;
         end
      end
      #1;
      wr_en = 1'b0; alt_wr_en = 1'b0;
   endtask

   task automatic sweep();
      for (int s = 0; s < 2; s++) begin
         for (int a = 0; a < 16; a++) begin
            probe((a < 8) ? "R2" : "R3", 1'(s), 4'(a), 4'(15 - a), 3'(a));
         end
      end
   endtask

   logic finished = 1'b0;

   initial begin
      clear_model();
      do_reset();

      // r1_: everything zero after reset, both selects.
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < 16; a++)
            probe("R1", 1'(s), 4'(a), 4'(a ^ 1), 3'(a));

      // Fill bank 0, the shared registers, then bank 1.
      for (int a = 0; a < 8; a++)
         do_write(1'b0, 1'b1, 4'(a), 32'h1000_0000 + 32'(a * 17), 1'b0, 3'd0, '0);
      for (int a = 8; a < 16; a++)
         do_write(1'b0, 1'b1, 4'(a), 32'hC0DE_0000 + 32'(a), 1'b0, 3'd0, '0);
      for (int a = 0; a < 8; a++)
         do_write(1'b1, 1'b1, 4'(a), 32'h2000_0000 + 32'(a * 19), 1'b0, 3'd0, '0);
      sweep();

      // R8: rapid bank toggling, same-cycle effect, contents kept.
      probe("R8", 1'b0, 4'd5, 4'd12, 3'd5);
      probe("R8", 1'b1, 4'd5, 4'd12, 3'd5);
      probe("R8", 1'b0, 4'd0, 4'd5, 3'd0);
      probe("R8", 1'b1, 4'd0, 4'd9, 3'd7);

      // R5: alternate writes leave the selected bank and shared registers alone.
      do_write(1'b0, 1'b0, 4'd3, '0, 1'b1, 3'd3, 32'hA17A_0003);
      probe("R5", 1'b0, 4'd3, 4'd11, 3'd3);
      probe("R5", 1'b1, 4'd3, 4'd11, 3'd3);
      do_write(1'b1, 1'b0, 4'd6, '0, 1'b1, 3'd6, 32'hA17B_0006);
      probe("R5", 1'b1, 4'd6, 4'd14, 3'd6);
      probe("R5", 1'b0, 4'd6, 4'd8, 3'd6);

      // R4: both ports write the same index of opposite banks together.
      do_write(1'b1, 1'b1, 4'd3, 32'h0000_00B1, 1'b1, 3'd3, 32'h0000_00B0);
      probe("R4", 1'b1, 4'd3, 4'd3, 3'd3);
      probe("R4", 1'b0, 4'd3, 4'd3, 3'd3);
      // Alternate write to entry 0 reaches idx_data only after a switch.
      do_write(1'b0, 1'b0, 4'd0, '0, 1'b1, 3'd0, 32'h1DC5_0000);
      probe("R7", 1'b0, 4'd0, 4'd1, 3'd0);
      probe("R7", 1'b1, 4'd0, 4'd1, 3'd0);

      // R9: write enable low changes nothing.
      do_write(1'b0, 1'b0, 4'd9, 32'hDEAD_BEEF, 1'b0, 3'd0, '0);
      do_write(1'b1, 1'b0, 4'd2, 32'hDEAD_BEEF, 1'b0, 3'd0, '0);
      probe("R9", 1'b0, 4'd9, 4'd2, 3'd2);
      probe("R9", 1'b1, 4'd2, 4'd9, 3'd2);

      // R10: select flips in the write cycle, write follows the new select.
      do_write(1'b0, 1'b0, 4'd0, '0, 1'b0, 3'd0, '0);
      do_write(1'b1, 1'b1, 4'd2, 32'h5E1E_C702, 1'b0, 3'd0, '0);
      probe("R10", 1'b0, 4'd2, 4'd2, 3'd2);
      probe("R10", 1'b1, 4'd2, 4'd2, 3'd2);
      do_write(1'b0, 1'b1, 4'd4, 32'h5E1E_C704, 1'b0, 3'd0, '0);
      probe("R10", 1'b1, 4'd4, 4'd4, 3'd4);
      probe("R10", 1'b0, 4'd4, 4'd4, 3'd4);

      sweep();

      // R1: reset in the middle of a run, with a write pending in that cycle.
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b1; wr_addr = 4'd9; wr_data = 32'h0BAD_0009;
      alt_wr_en = 1'b1; alt_addr = 3'd1; alt_wr_data = 32'h0BAD_0001;
      repeat (2) @(posedge clk);
      clear_model();
      #1 rst = 1'b0; wr_en = 1'b0; alt_wr_en = 1'b0;
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < 16; a++)
            probe("R1", 1'(s), 4'(a), 4'(15 - a), 3'(a));

      #5;
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   // Watchdog.
   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired, actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule